// File: doc/BRIEF.md
# I2C Master Byte Command Engine

This block runs the controller side of an I2C bus one byte at a time. Software, or a sequencer above it, writes a small command word. Each set bit asks for one bus operation: a START condition, sending a byte, receiving a byte (with the option to refuse it), or a STOP condition. Bits written in one word, or in several writes while the engine is busy, accumulate in a pending set. The engine always drains that set in the order START, send, receive, STOP. One write can therefore address a target and read its first data byte.

The bus pins are open-drain. An output of 1 releases the line, and the levels sensed on the bus come back as inputs. Bit timing follows an external tick: every bit takes four ticks, and SCL is high during the middle two. Each finished operation reports a one-cycle event pulse. When the engine loses arbitration, it releases both lines and drops every pending command.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset, the pending set is zero, SCL and SDA are both released (outputs 1), and no event pulse is active.
- R2: Command bits sit at these positions: START = bit 0, send = bit 1, receive = bit 3, refuse-last (answer the received byte with NACK) = bit 4, STOP = bit 5. A write ORs them into `pend_o` at the same positions, visible the cycle after the strobe. Bit 2 is ignored and always reads 0.
- R3: Pending commands run in the order START, send, receive, STOP, whatever order or write they arrived in.
- R4: A send shifts out the byte on `tx_byte_i`, captured when the send begins, MSB first. It then samples the ninth bit: low gives `ev_tx_ack_o`, high gives `ev_tx_nak_o`. START plus send in one write puts a START condition ahead of the address byte.
- R5: A receive shifts in eight bits MSB first. It answers with SDA low (ACK), or with SDA high (NACK) when refuse-last was pending. It then pulses `ev_rx_done_o` in the same cycle that `rx_byte_o` takes the new byte.
- R6: A STOP raises SDA while SCL is high, leaves both lines released, and pulses `ev_stop_o`.
- R7: Arbitration is lost when a sent 1 is sensed low while SCL is sensed high at the sample point. The engine then pulses `ev_arb_lost_o`, releases both lines, reports no ACK or NACK for that byte, and clears the whole pending set. Commands that were pending never run.
- R8: SCL changes only in a tick cycle. During data and acknowledge bits, SDA changes only while SCL is low, so a target never sees a spurious START or STOP.
- R9: Each event is a single-cycle pulse, and at most one event is active in any cycle.
- R10: A command written while an operation is in progress is held pending and runs after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 6 | Command bits (positions per R2) |
| tx_byte_i | input | 8 | Byte to send, captured when a send begins |
| tick_i | input | 1 | Quarter-bit timing tick |
| scl_o | output | 1 | SCL drive, 1 = released |
| sda_o | output | 1 | SDA drive, 1 = released |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| rx_byte_o | output | 8 | Last received byte |
| pend_o | output | 6 | Pending command bits |
| ev_tx_ack_o | output | 1 | Sent byte acknowledged |
| ev_tx_nak_o | output | 1 | Sent byte not acknowledged |
| ev_rx_done_o | output | 1 | Byte received |
| ev_stop_o | output | 1 | STOP completed |
| ev_arb_lost_o | output | 1 | Arbitration lost |

## Verification
Two actions can land on the pending set in the same cycle. The first is the sequencer taking the next command; the second is a new command write. This is provoked by writing START plus send and then, on the very next cycle, writing STOP. `pend_o` must then show send plus STOP together, and those must run in that order.

A second collision is a flush that coincides with the sequencer going idle. It is provoked by pulling SDA low during the address byte while STOP is queued behind the send. The check is that the arbitration event arrives with the pending set already empty and that no STOP event follows.

A behavioural target model on the wired-AND bus supplies the ACK and read data. It also counts the START and STOP conditions it sees, which exposes any SDA edge made while SCL was high.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int CMD_W   = 6;
  localparam int B_START = 0;
  localparam int B_TX    = 1;
  localparam int B_RX    = 3;
  localparam int B_LAST  = 4;
  localparam int B_STOP  = 5;

  typedef enum logic [1:0] {BIT_START, BIT_STOP, BIT_WR, BIT_RD} bit_op_e;
  typedef enum logic [2:0] {Q_NONE, Q_START, Q_TX, Q_RX, Q_STOP} q_op_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_START, SQ_BYTE, SQ_STOP} sq_state_e;
endpackage

// File: rtl/i2c_cmd_queue.sv
module i2c_cmd_queue
  import i2c_cmd_pkg::*;
#(
  parameter int W = CMD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_bits_i,
  input  logic         flush_i,
  input  logic         take_i,
  output q_op_e        next_op_o,
  output logic         next_last_o,
  output logic [W-1:0] pend_o
);
  localparam logic [W-1:0] CMD_MASK = W'((1 << B_START) | (1 << B_TX) | (1 << B_RX) |
                                         (1 << B_LAST) | (1 << B_STOP));

  logic [W-1:0] pend_q, take_mask, wr_mask;

  always_comb begin
    if (pend_q[B_START])     next_op_o = Q_START;
    else if (pend_q[B_TX])   next_op_o = Q_TX;
    else if (pend_q[B_RX])   next_op_o = Q_RX;
    else if (pend_q[B_STOP]) next_op_o = Q_STOP;
    else                     next_op_o = Q_NONE;
  end

  assign next_last_o = pend_q[B_LAST];

  always_comb begin
    take_mask = '0;
    if (take_i) begin
      case (next_op_o)
        Q_START: take_mask[B_START] = 1'b1;
        Q_TX:    take_mask[B_TX]    = 1'b1;
        Q_RX: begin
          take_mask[B_RX]   = 1'b1;
          take_mask[B_LAST] = 1'b1;
        end
        Q_STOP:  take_mask[B_STOP]  = 1'b1;
        default: take_mask = '0;
      endcase
    end
  end

  assign wr_mask = wr_i ? (wr_bits_i & CMD_MASK) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= '0;
    else if (flush_i) pend_q <= '0;
    else              pend_q <= (pend_q & ~take_mask) | wr_mask;
  end

  assign pend_o = pend_q;

  // R7
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (pend_q == '0));

  // R2
  wr_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !flush_i && !take_i) |=>
      ((pend_q & $past(wr_bits_i & CMD_MASK)) == $past(wr_bits_i & CMD_MASK)));
endmodule

// File: rtl/i2c_bit_phy.sv
module i2c_bit_phy
  import i2c_cmd_pkg::*;
#(
  parameter int PHASES = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tick_i,
  input  logic    go_i,
  input  bit_op_e op_i,
  input  logic    val_i,
  input  logic    scl_i,
  input  logic    sda_i,
  output logic    scl_o,
  output logic    sda_o,
  output logic    done_o,
  output logic    rx_o,
  output logic    arb_o
);
  localparam int PH_W = $clog2(PHASES);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

  logic            busy_q, val_q, scl_q, sda_q, done_q, rx_q, arb_q;
  logic [PH_W-1:0] phase_q;
  bit_op_e         op_q;
  logic            scl_n, sda_n, dbit, lost;

  // phase 0: SCL low, 1..2: SCL high, 3: SCL low (data ops)
  always_comb begin
    dbit  = (op_q == BIT_WR) ? val_q : 1'b1;
    scl_n = scl_q;
    sda_n = sda_q;
    case (op_q)
      BIT_START: begin
        scl_n = (phase_q == 2'd1) || (phase_q == 2'd2);
        sda_n = (phase_q <= 2'd1);
      end
      BIT_STOP: begin
        scl_n = (phase_q != 2'd0);
        sda_n = (phase_q >= 2'd2);
      end
      default: begin
        scl_n = (phase_q == 2'd1) || (phase_q == 2'd2);
        sda_n = dbit;
      end
    endcase
  end

  assign lost = (op_q == BIT_WR) && val_q && scl_i && !sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
      op_q    <= BIT_RD;
      val_q   <= 1'b1;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      done_q  <= 1'b0;
      rx_q    <= 1'b1;
      arb_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      arb_q  <= 1'b0;
      if (!busy_q && go_i) begin
        busy_q  <= 1'b1;
        op_q    <= op_i;
        val_q   <= val_i;
        phase_q <= '0;
      end else if (busy_q && tick_i) begin
        if (phase_q == PH_LAST) begin
          rx_q    <= sda_i;
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          phase_q <= '0;
          if (lost) begin
            arb_q <= 1'b1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
          end else begin
            scl_q <= scl_n;
            sda_q <= sda_n;
          end
        end else begin
          scl_q   <= scl_n;
          sda_q   <= sda_n;
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  assign scl_o  = scl_q;
  assign sda_o  = sda_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign arb_o  = arb_q;

  // R8
  scl_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(scl_q));

  // R8
  sda_low_scl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && (op_q == BIT_WR || op_q == BIT_RD) && !$stable(sda_q)) |-> !scl_q);
endmodule

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq
  import i2c_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  q_op_e             next_op_i,
  input  logic              next_last_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              bit_done_i,
  input  logic              bit_rx_i,
  input  logic              bit_arb_i,
  output logic              take_o,
  output logic              flush_o,
  output logic              bit_go_o,
  output bit_op_e           bit_op_o,
  output logic              bit_val_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              ev_tx_ack_o,
  output logic              ev_tx_nak_o,
  output logic              ev_rx_done_o,
  output logic              ev_stop_o,
  output logic              ev_arb_o
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] CNT_ACK = CW'(DATA_W);

  sq_state_e         state_q;
  logic              is_tx_q, last_q, launched_q;
  logic [DATA_W-1:0] sh_q, rx_q;
  logic [CW-1:0]     cnt_q;
  logic              ack_q, nak_q, rxd_q, stp_q, arb_q;

  assign take_o   = (state_q == SQ_IDLE) && (next_op_i != Q_NONE);
  assign flush_o  = (state_q != SQ_IDLE) && bit_done_i && bit_arb_i;
  assign bit_go_o = (state_q != SQ_IDLE) && !launched_q;

  always_comb begin
    bit_op_o  = BIT_RD;
    bit_val_o = 1'b1;
    case (state_q)
      SQ_START: bit_op_o = BIT_START;
      SQ_STOP:  bit_op_o = BIT_STOP;
      SQ_BYTE: begin
        if (cnt_q < CNT_ACK) begin
          bit_op_o  = is_tx_q ? BIT_WR : BIT_RD;
          bit_val_o = is_tx_q ? sh_q[DATA_W-1] : 1'b1;
        end else begin
          bit_op_o  = is_tx_q ? BIT_RD : BIT_WR;
          bit_val_o = is_tx_q ? 1'b1 : last_q;
        end
      end
      default: bit_op_o = BIT_RD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SQ_IDLE;
      is_tx_q    <= 1'b0;
      last_q     <= 1'b0;
      launched_q <= 1'b0;
      sh_q       <= '0;
      rx_q       <= '0;
      cnt_q      <= '0;
      ack_q      <= 1'b0;
      nak_q      <= 1'b0;
      rxd_q      <= 1'b0;
      stp_q      <= 1'b0;
      arb_q      <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      nak_q <= 1'b0;
      rxd_q <= 1'b0;
      stp_q <= 1'b0;
      arb_q <= 1'b0;
      if (state_q == SQ_IDLE) begin
        launched_q <= 1'b0;
        cnt_q      <= '0;
        if (take_o) begin
          case (next_op_i)
            Q_START: state_q <= SQ_START;
            Q_TX: begin
              state_q <= SQ_BYTE;
              is_tx_q <= 1'b1;
              sh_q    <= tx_byte_i;
            end
            Q_RX: begin
              state_q <= SQ_BYTE;
              is_tx_q <= 1'b0;
              last_q  <= next_last_i;
            end
            Q_STOP:  state_q <= SQ_STOP;
            default: state_q <= SQ_IDLE;
          endcase
        end
      end else begin
        if (bit_go_o) launched_q <= 1'b1;
        if (bit_done_i) begin
          launched_q <= 1'b0;
          if (bit_arb_i) begin
            arb_q   <= 1'b1;
            state_q <= SQ_IDLE;
          end else begin
            case (state_q)
              SQ_START: state_q <= SQ_IDLE;
              SQ_STOP: begin
                stp_q   <= 1'b1;
                state_q <= SQ_IDLE;
              end
              SQ_BYTE: begin
                if (cnt_q < CNT_ACK) begin
                  sh_q  <= {sh_q[DATA_W-2:0], bit_rx_i};
                  cnt_q <= cnt_q + 1'b1;
                end else begin
                  state_q <= SQ_IDLE;
                  if (is_tx_q) begin
                    ack_q <= !bit_rx_i;
                    nak_q <= bit_rx_i;
                  end else begin
                    rxd_q <= 1'b1;
                    rx_q  <= sh_q;
                  end
                end
              end
              default: state_q <= SQ_IDLE;
            endcase
          end
        end
      end
    end
  end

  assign rx_byte_o    = rx_q;
  assign ev_tx_ack_o  = ack_q;
  assign ev_tx_nak_o  = nak_q;
  assign ev_rx_done_o = rxd_q;
  assign ev_stop_o    = stp_q;
  assign ev_arb_o     = arb_q;

  // R9
  one_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ack_q, nak_q, rxd_q, stp_q, arb_q}));

  // R9
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q || nak_q || rxd_q || stp_q) |=> !(ack_q || nak_q || rxd_q || stp_q));
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PHASES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              tick_i,
  output logic              scl_o,
  output logic              sda_o,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic [CMD_W-1:0]  pend_o,
  output logic              ev_tx_ack_o,
  output logic              ev_tx_nak_o,
  output logic              ev_rx_done_o,
  output logic              ev_stop_o,
  output logic              ev_arb_lost_o
);
  q_op_e   next_op;
  logic    next_last, take, flush;
  logic    bit_go, bit_val, bit_done, bit_rx, bit_arb;
  bit_op_e bit_op;

  i2c_cmd_queue #(.W(CMD_W)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cmd_we_i),
    .wr_bits_i  (cmd_i),
    .flush_i    (flush),
    .take_i     (take),
    .next_op_o  (next_op),
    .next_last_o(next_last),
    .pend_o     (pend_o)
  );

  i2c_byte_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .next_op_i   (next_op),
    .next_last_i (next_last),
    .tx_byte_i   (tx_byte_i),
    .bit_done_i  (bit_done),
    .bit_rx_i    (bit_rx),
    .bit_arb_i   (bit_arb),
    .take_o      (take),
    .flush_o     (flush),
    .bit_go_o    (bit_go),
    .bit_op_o    (bit_op),
    .bit_val_o   (bit_val),
    .rx_byte_o   (rx_byte_o),
    .ev_tx_ack_o (ev_tx_ack_o),
    .ev_tx_nak_o (ev_tx_nak_o),
    .ev_rx_done_o(ev_rx_done_o),
    .ev_stop_o   (ev_stop_o),
    .ev_arb_o    (ev_arb_lost_o)
  );

  i2c_bit_phy #(.PHASES(PHASES)) u_phy (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .go_i  (bit_go),
    .op_i  (bit_op),
    .val_i (bit_val),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .scl_o (scl_o),
    .sda_o (sda_o),
    .done_o(bit_done),
    .rx_o  (bit_rx),
    .arb_o (bit_arb)
  );

  // R7
  arb_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_arb_lost_o |-> (scl_o && sda_o && pend_o == '0));

  // R6
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_stop_o |-> (scl_o && sda_o));
endmodule

// File: tb/sim_i2c_cmd_engine.sv
module sim_i2c_cmd_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [5:0] cmd = '0;
  logic [7:0] tx_byte = '0;
  logic [1:0] tdiv = '0;
  logic       tick;
  logic       scl_o, sda_o, slv_sda = 1'b1, arb_pull = 1'b0;
  logic [7:0] rx_byte;
  logic [5:0] pend;
  logic       ev_ack, ev_nak, ev_rx, ev_stop, ev_arb;
  wire        scl_bus = scl_o;
  wire        sda_bus = sda_o & slv_sda & ~arb_pull;

  int n_chk = 0, n_err = 0;
  bit ended = 1'b0;
  int ev_log[$];

  always #5 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);

  i2c_cmd_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_i(cmd), .tx_byte_i(tx_byte),
    .tick_i(tick), .scl_o(scl_o), .sda_o(sda_o), .scl_i(scl_bus), .sda_i(sda_bus),
    .rx_byte_o(rx_byte), .pend_o(pend), .ev_tx_ack_o(ev_ack), .ev_tx_nak_o(ev_nak),
    .ev_rx_done_o(ev_rx), .ev_stop_o(ev_stop), .ev_arb_lost_o(ev_arb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural target on the wired-AND bus
  logic       ack_en = 1'b1;
  logic       p_scl = 1'b1, p_sda = 1'b1;
  int         mode = 0, bcnt = 0, rcnt = 0, n_start = 0, n_stop = 0;
  bit         acked = 1'b0;
  logic [7:0] sh = '0, rsh = '0;
  logic [7:0] rd_q[$];
  logic [7:0] got_q[$];
  bit         mack_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 0; bcnt = 0; rcnt = 0; acked = 1'b0;
      slv_sda <= 1'b1;
    end else if (p_scl && scl_bus && p_sda && !sda_bus) begin
      mode = 1; bcnt = 0; acked = 1'b0; n_start++;
      slv_sda <= 1'b1;
    end else if (p_scl && scl_bus && !p_sda && sda_bus) begin
      mode = 0; n_stop++;
      slv_sda <= 1'b1;
    end else if (!p_scl && scl_bus) begin
      if ((mode == 1 || mode == 2) && bcnt < 8) begin
        sh = {sh[6:0], sda_bus};
        bcnt++;
      end else if (mode == 3) begin
        if (rcnt == 8) mack_q.push_back(sda_bus);
        rcnt++;
      end
    end else if (p_scl && !scl_bus) begin
      if (mode == 1 || mode == 2) begin
        if (bcnt == 8 && !acked) begin
          slv_sda <= ~ack_en;
          acked = 1'b1;
        end else if (acked) begin
          slv_sda <= 1'b1;
          bcnt = 0; acked = 1'b0;
          got_q.push_back(sh);
          if (mode == 1) begin
            if (!ack_en) mode = 0;
            else if (sh[0]) begin
              mode = 3; rcnt = 0;
              rsh = (rd_q.size() > 0) ? rd_q.pop_front() : 8'hFF;
              slv_sda <= rsh[7];
            end else mode = 2;
          end
        end
      end else if (mode == 3) begin
        if (rcnt < 8) slv_sda <= rsh[7-rcnt];
        else if (rcnt == 8) slv_sda <= 1'b1;
        else if (mack_q[mack_q.size()-1] == 1'b0) begin
          rcnt = 0;
          rsh = (rd_q.size() > 0) ? rd_q.pop_front() : 8'hFF;
          slv_sda <= rsh[7];
        end else begin
          slv_sda <= 1'b1;
          mode = 0;
        end
      end
    end
    p_scl = scl_bus;
    p_sda = sda_bus;
  end

  // per-cycle event monitor: codes 0 ack, 1 nak, 2 rx, 3 stop, 4 arb
  always @(negedge clk) begin
    if (rst_n) begin
      logic [4:0] evv;
      evv = {ev_arb, ev_stop, ev_rx, ev_nak, ev_ack};
      if (evv != 5'd0) begin
        chk($onehot0(evv), "R9 single event", evv, 1);
        if (ev_ack) ev_log.push_back(0);
        else if (ev_nak) ev_log.push_back(1);
        else if (ev_rx) ev_log.push_back(2);
        else if (ev_stop) ev_log.push_back(3);
        else ev_log.push_back(4);
      end
    end
  end

  task automatic send(input logic [5:0] c, input logic [7:0] b);
    cmd_we  = 1'b1;
    cmd     = c;
    tx_byte = b;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_ev(input int n);
    for (int i = 0; i < 4000; i++) begin
      if (ev_log.size() >= n) break;
      @(negedge clk);
    end
    chk(ev_log.size() >= n, "event wait", ev_log.size(), n);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(pend == 6'h00, "R1 pend", pend, 0);
    chk(scl_o && sda_o, "R1 lines", {scl_o, sda_o}, 3);
    chk({ev_ack, ev_nak, ev_rx, ev_stop, ev_arb} == 5'd0, "R1 events",
        {ev_ack, ev_nak, ev_rx, ev_stop, ev_arb}, 0);

    // R2 + R10: start+send, then stop written while start runs
    base = ev_log.size();
    send(6'h03, 8'hA0);
    chk(pend == 6'h03, "R2 pend after write", pend, 6'h03);
    send(6'h20, 8'hA0);
    chk(pend == 6'h22, "R10 queued while busy", pend, 6'h22);
    wait_ev(base + 2);
    chk(ev_log[base] == 0, "R4 address ack", ev_log[base], 0);
    chk(ev_log[base+1] == 3, "R10 stop after send", ev_log[base+1], 3);
    chk(got_q[got_q.size()-1] == 8'hA0, "R4 address byte", got_q[got_q.size()-1], 8'hA0);
    @(negedge clk);
    chk(scl_o && sda_o, "R6 lines released", {scl_o, sda_o}, 3);

    // R4 data bytes MSB first
    base = ev_log.size();
    send(6'h03, 8'hA0);
    wait_ev(base + 1);
    send(6'h02, 8'h3C);
    wait_ev(base + 2);
    chk(got_q[got_q.size()-1] == 8'h3C, "R4 data 3C", got_q[got_q.size()-1], 8'h3C);
    send(6'h02, 8'hC3);
    wait_ev(base + 3);
    chk(got_q[got_q.size()-1] == 8'hC3, "R4 data C3", got_q[got_q.size()-1], 8'hC3);
    chk(ev_log[base+2] == 0, "R4 data ack", ev_log[base+2], 0);
    send(6'h20, 8'hC3);
    wait_ev(base + 4);
    chk(ev_log[base+3] == 3, "R6 stop event", ev_log[base+3], 3);

    // R4 nak
    ack_en = 1'b0;
    base = ev_log.size();
    send(6'h03, 8'hA2);
    wait_ev(base + 1);
    chk(ev_log[base] == 1, "R4 nak event", ev_log[base], 1);
    ack_en = 1'b1;
    send(6'h20, 8'hA2);
    wait_ev(base + 2);

    // R5 read with ack then refuse-last
    rd_q.push_back(8'h96);
    rd_q.push_back(8'h5A);
    base = ev_log.size();
    send(6'h0B, 8'hA1);
    wait_ev(base + 2);
    chk(ev_log[base+1] == 2, "R5 rx done", ev_log[base+1], 2);
    chk(rx_byte == 8'h96, "R5 rx byte 96", rx_byte, 8'h96);
    chk(mack_q[mack_q.size()-1] == 1'b0, "R5 ack driven", mack_q[mack_q.size()-1], 0);
    send(6'h18, 8'hA1);
    wait_ev(base + 3);
    chk(rx_byte == 8'h5A, "R5 rx byte 5A", rx_byte, 8'h5A);
    chk(mack_q[mack_q.size()-1] == 1'b1, "R5 nack on last", mack_q[mack_q.size()-1], 1);
    send(6'h20, 8'hA1);
    wait_ev(base + 4);

    // R3 + R2: all bits in one write, bit 2 ignored
    rd_q.push_back(8'hE7);
    base = ev_log.size();
    send(6'h3F, 8'hA1);
    chk(pend == 6'h3B, "R2 bit2 ignored", pend, 6'h3B);
    wait_ev(base + 3);
    chk(ev_log[base] == 0 && ev_log[base+1] == 2 && ev_log[base+2] == 3, "R3 order",
        ev_log[base] * 100 + ev_log[base+1] * 10 + ev_log[base+2], 23);
    chk(rx_byte == 8'hE7, "R3 rx byte", rx_byte, 8'hE7);
    chk(mack_q[mack_q.size()-1] == 1'b1, "R3 last nacked", mack_q[mack_q.size()-1], 1);
    @(negedge clk);
    // R8: no spurious start/stop seen by the target
    chk(n_start == 5, "R8 start count", n_start, 5);
    chk(n_stop == 5, "R8 stop count", n_stop, 5);

    // R7 arbitration loss
    base = ev_log.size();
    begin
      int s0;
      s0 = n_start;
      send(6'h23, 8'hFF);
      for (int i = 0; i < 200 && n_start == s0; i++) @(negedge clk);
    end
    arb_pull = 1'b1;
    for (int i = 0; i < 400 && ev_log.size() == base; i++) begin
      @(negedge clk);
      if (ev_arb) begin
        chk(pend == 6'h00, "R7 pend flushed", pend, 0);
        chk(scl_o && sda_o, "R7 lines released", {scl_o, sda_o}, 3);
      end
    end
    chk(ev_log.size() == base + 1 && ev_log[base] == 4, "R7 arb event",
        ev_log.size() - base, 1);
    arb_pull = 1'b0;
    repeat (300) @(negedge clk);
    chk(ev_log.size() == base + 1, "R7 no later events", ev_log.size() - base, 1);
    chk(pend == 6'h00, "R7 pend stays empty", pend, 0);

    finish_run();
  end
endmodule